// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts, for a memory instruction entering an out-of-order core, which older in-flight store it should wait for. It learns from ordering violations: when a load is found to have run ahead of a store it needed, the two program counters are trained into the same store set. Every store set remembers the sequence number of the youngest store of that set that has been fetched and not yet issued or squashed. A later lookup of any member of the set returns that sequence number, and the scheduler holds the instruction until that store issues.

Two tables make up the state. The set-ID table is indexed by bits of the program counter and maps it to a store set ID. The last-store table is indexed by store set ID and holds a sequence number and the owning thread. Each entry of both tables has a valid bit that is kept apart from the payload. Store insert, store issue, per-thread squash and a global clear keep the last-store table up to date. Load insert is accepted for interface symmetry and changes nothing.

Top module: `sspred_top`

## Requirements
- R1: The set-ID table index of a PC is (PC >> OFF_BITS) & (ID_ENTRIES-1). With the defaults (OFF_BITS=2, ID_ENTRIES=64) this is PC[7:2], so PCs that differ only above bit 7 share one entry.
- R2: On a violation where neither the store's entry nor the load's entry is valid, both entries become valid and hold (store PC ^ (store PC >> 10)) % SET_ENTRIES.
- R3: On a violation where exactly one of the two entries is valid, the other entry becomes valid and takes the same set ID. This holds whichever of the two is the valid one.
- R4: On a violation where both entries are valid, both are given the smaller of the two set IDs.
- R5: A store insert writes its sequence number and thread into the last-store entry of its set, and marks that entry valid, only when the store's set-ID entry is valid. Otherwise it changes nothing.
- R6: A lookup presented with look_v_i in one cycle raises look_vld_o in the next cycle. look_dep_o then holds the predicted producer's sequence number when both the set-ID entry and that set's last-store entry are valid, and zero otherwise.
- R7: A store issue (iss_is_st_i=1) whose set's last-store entry is valid and holds the same sequence number invalidates that entry. An issue with a different sequence number, or with iss_is_st_i=0, has no effect.
- R8: A squash invalidates every valid last-store entry whose thread equals sq_tid_i and whose sequence number is strictly greater than sq_seq_i. Entries of other threads, and entries equal to or older than the squash point, are kept.
- R9: Clear invalidates every entry of both tables. Load insert changes no state.
- R10: After reset all entries are invalid, look_vld_o is 0 and look_dep_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Invalidate both tables |
| viol_v_i | input | 1 | Violation training strobe |
| viol_st_pc_i | input | PC_W | PC of the older store |
| viol_ld_pc_i | input | PC_W | PC of the younger load |
| st_ins_v_i | input | 1 | Store insert strobe |
| st_ins_pc_i | input | PC_W | Inserted store PC |
| st_ins_seq_i | input | SEQ_W | Inserted store sequence number |
| st_ins_tid_i | input | TID_W | Inserted store thread |
| ld_ins_v_i | input | 1 | Load insert strobe (no effect) |
| ld_ins_pc_i | input | PC_W | Inserted load PC |
| ld_ins_seq_i | input | SEQ_W | Inserted load sequence number |
| look_v_i | input | 1 | Lookup strobe |
| look_pc_i | input | PC_W | PC to look up |
| look_vld_o | output | 1 | Lookup result valid, one cycle after look_v_i |
| look_dep_o | output | SEQ_W | Predicted producer sequence number, 0 for none |
| iss_v_i | input | 1 | Issue notify strobe |
| iss_pc_i | input | PC_W | Issued instruction PC |
| iss_seq_i | input | SEQ_W | Issued instruction sequence number |
| iss_is_st_i | input | 1 | Issued instruction is a store |
| sq_v_i | input | 1 | Squash strobe |
| sq_tid_i | input | TID_W | Thread being squashed |
| sq_seq_i | input | SEQ_W | Squash point; younger entries are dropped |

## Verification
All table updates (training, store insert, issue, squash, clear) land at the clock edge that samples their strobe, so they are visible to a lookup strobed in the next cycle. The lookup answer is due exactly one edge after its strobe. The bench drives each operation on a falling edge, lets one rising edge pass, and samples look_vld_o and look_dep_o at the following falling edge. Every table effect is therefore observed through a later lookup, never by reading internals.

// File: rtl/sspred_pkg.sv
package sspred_pkg;

  // Set-ID table slot for a PC: drop the low offset bits, keep log2(entries) bits.
  function automatic logic [31:0] tab_index(input logic [63:0] pc,
                                            input int unsigned off,
                                            input int unsigned entries);
    return 32'((pc >> off) & (64'(entries) - 64'd1));
  endfunction

  // Fresh store set ID folded from a PC.
  function automatic logic [31:0] set_hash(input logic [63:0] pc,
                                           input int unsigned entries);
    return 32'((pc ^ (pc >> 10)) % 64'(entries));
  endfunction

  function automatic logic [31:0] pick_smaller(input logic [31:0] a,
                                               input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sspred_idtab.sv
module sspred_idtab
  import sspred_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ID_ENTRIES  = 64,
  parameter int SET_ENTRIES = 16,
  parameter int OFF_BITS    = 2,
  parameter int NRD         = 3,
  localparam int IDX_W = $clog2(ID_ENTRIES),
  localparam int SET_W = $clog2(SET_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        viol_v_i,
  input  logic [PC_W-1:0]             viol_st_pc_i,
  input  logic [PC_W-1:0]             viol_ld_pc_i,
  input  logic [NRD-1:0][PC_W-1:0]    rd_pc_i,
  output logic [NRD-1:0]              rd_vld_o,
  output logic [NRD-1:0][SET_W-1:0]   rd_id_o
);

  logic [SET_W-1:0]      id_q [ID_ENTRIES];
  logic [ID_ENTRIES-1:0] vld_q;

  // Training event decode, brought out as named wires.
  logic [IDX_W-1:0] st_idx, ld_idx;
  logic             st_v, ld_v;
  logic [SET_W-1:0] st_id, ld_id, fresh_id, merged_id;
  logic             train_ev;

  assign st_idx   = IDX_W'(tab_index(64'(viol_st_pc_i), OFF_BITS, ID_ENTRIES));
  assign ld_idx   = IDX_W'(tab_index(64'(viol_ld_pc_i), OFF_BITS, ID_ENTRIES));
  assign st_v     = vld_q[st_idx];
  assign ld_v     = vld_q[ld_idx];
  assign st_id    = id_q[st_idx];
  assign ld_id    = id_q[ld_idx];
  assign fresh_id = SET_W'(set_hash(64'(viol_st_pc_i), SET_ENTRIES));
  assign train_ev = viol_v_i && !clr_i;

  always_comb begin
    unique case ({st_v, ld_v})
      2'b00:   merged_id = fresh_id;
      2'b10:   merged_id = st_id;
      2'b01:   merged_id = ld_id;
      default: merged_id = SET_W'(pick_smaller(32'(st_id), 32'(ld_id)));
    endcase
  end

  always_ff @(posedge clk) begin
    if (train_ev) begin
      id_q[st_idx] <= merged_id;
      id_q[ld_idx] <= merged_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      vld_q <= '0;
    end else if (viol_v_i) begin
      vld_q[st_idx] <= 1'b1;
      vld_q[ld_idx] <= 1'b1;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IDX_W-1:0] ridx;
    assign ridx        = IDX_W'(tab_index(64'(rd_pc_i[p]), OFF_BITS, ID_ENTRIES));
    assign rd_vld_o[p] = vld_q[ridx];
    assign rd_id_o[p]  = id_q[ridx];
  end

  // R2: untrained pair receives the hash of the store PC
  a_r2_fresh_hash: assert property (@(posedge clk) disable iff (!rst_n)
    (train_ev && !st_v && !ld_v) |=> (id_q[$past(st_idx)] == $past(fresh_id)));

  // R4: after any training both entries are valid and agree
  a_r4_pair_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    train_ev |=> (vld_q[$past(st_idx)] && vld_q[$past(ld_idx)] &&
                  id_q[$past(st_idx)] == id_q[$past(ld_idx)]));

  // R4: merging two valid sets never picks the larger ID
  a_r4_merge_min: assert property (@(posedge clk) disable iff (!rst_n)
    (train_ev && st_v && ld_v) |=> (id_q[$past(st_idx)] <= $past(st_id) &&
                                    id_q[$past(st_idx)] <= $past(ld_id)));

  // R9: clear empties the set-ID table
  a_r9_idtab_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (vld_q == '0));

endmodule

// File: rtl/sspred_lastst.sv
module sspred_lastst #(
  parameter int SEQ_W       = 16,
  parameter int SET_ENTRIES = 16,
  parameter int THREADS     = 2,
  localparam int SET_W = $clog2(SET_ENTRIES),
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   ins_v_i,
  input  logic [SET_W-1:0]       ins_set_i,
  input  logic [SEQ_W-1:0]       ins_seq_i,
  input  logic [TID_W-1:0]       ins_tid_i,
  input  logic                   iss_v_i,
  input  logic [SET_W-1:0]       iss_set_i,
  input  logic [SEQ_W-1:0]       iss_seq_i,
  input  logic                   sq_v_i,
  input  logic [TID_W-1:0]       sq_tid_i,
  input  logic [SEQ_W-1:0]       sq_seq_i,
  input  logic [SET_W-1:0]       rd_set_i,
  output logic                   rd_vld_o,
  output logic [SEQ_W-1:0]       rd_seq_o,
  output logic [SET_ENTRIES-1:0] vld_vec_o
);

  logic [SET_ENTRIES-1:0][SEQ_W-1:0] seq_all;
  logic [SET_ENTRIES-1:0]            wr_ev, kill_iss, kill_sq;

  for (genvar e = 0; e < SET_ENTRIES; e++) begin : g_ent
    logic             vld_q;
    logic [SEQ_W-1:0] seq_q;
    logic [TID_W-1:0] tid_q;

    assign wr_ev[e]    = ins_v_i && (ins_set_i == SET_W'(e));
    assign kill_iss[e] = iss_v_i && (iss_set_i == SET_W'(e)) && vld_q &&
                         (seq_q == iss_seq_i);
    assign kill_sq[e]  = sq_v_i && vld_q && (tid_q == sq_tid_i) &&
                         (seq_q > sq_seq_i);

    always_ff @(posedge clk) begin
      if (!rst_n || clr_i)                 vld_q <= 1'b0;
      else if (wr_ev[e])                   vld_q <= 1'b1;
      else if (kill_iss[e] || kill_sq[e])  vld_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wr_ev[e]) begin
        seq_q <= ins_seq_i;
        tid_q <= ins_tid_i;
      end
    end

    assign seq_all[e]   = seq_q;
    assign vld_vec_o[e] = vld_q;

    // R7: a matching store issue retires the entry
    a_r7_issue_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_iss[e] && !clr_i && !wr_ev[e]) |=> !vld_q);

    // R8: squash drops younger entries of its thread
    a_r8_squash_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_sq[e] && !clr_i && !wr_ev[e]) |=> !vld_q);

    // R8: entries of another thread survive a squash
    a_r8_other_thread: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_v_i && vld_q && tid_q != sq_tid_i && !clr_i && !kill_iss[e]) |=> vld_q);

    // R5: an accepted insert is recorded
    a_r5_insert_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev[e] && !clr_i) |=> (vld_q && seq_q == $past(ins_seq_i)));
  end

  assign rd_vld_o = vld_vec_o[rd_set_i];
  assign rd_seq_o = seq_all[rd_set_i];

  // R9: clear empties the last-store table
  a_r9_lastst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (vld_vec_o == '0));

endmodule

// File: rtl/sspred_top.sv
module sspred_top #(
  parameter int PC_W        = 32,
  parameter int SEQ_W       = 16,
  parameter int ID_ENTRIES  = 64,
  parameter int SET_ENTRIES = 16,
  parameter int THREADS     = 2,
  parameter int OFF_BITS    = 2,
  localparam int SET_W = $clog2(SET_ENTRIES),
  localparam int TID_W = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             viol_v_i,
  input  logic [PC_W-1:0]  viol_st_pc_i,
  input  logic [PC_W-1:0]  viol_ld_pc_i,
  input  logic             st_ins_v_i,
  input  logic [PC_W-1:0]  st_ins_pc_i,
  input  logic [SEQ_W-1:0] st_ins_seq_i,
  input  logic [TID_W-1:0] st_ins_tid_i,
  input  logic             ld_ins_v_i,
  input  logic [PC_W-1:0]  ld_ins_pc_i,
  input  logic [SEQ_W-1:0] ld_ins_seq_i,
  input  logic             look_v_i,
  input  logic [PC_W-1:0]  look_pc_i,
  output logic             look_vld_o,
  output logic [SEQ_W-1:0] look_dep_o,
  input  logic             iss_v_i,
  input  logic [PC_W-1:0]  iss_pc_i,
  input  logic [SEQ_W-1:0] iss_seq_i,
  input  logic             iss_is_st_i,
  input  logic             sq_v_i,
  input  logic [TID_W-1:0] sq_tid_i,
  input  logic [SEQ_W-1:0] sq_seq_i
);

  localparam int RD_LOOK = 0;
  localparam int RD_INS  = 1;
  localparam int RD_ISS  = 2;
  localparam int NRD     = 3;

  logic [NRD-1:0][PC_W-1:0]  rd_pc;
  logic [NRD-1:0]            rd_vld;
  logic [NRD-1:0][SET_W-1:0] rd_id;

  assign rd_pc[RD_LOOK] = look_pc_i;
  assign rd_pc[RD_INS]  = st_ins_pc_i;
  assign rd_pc[RD_ISS]  = iss_pc_i;

  sspred_idtab #(
    .PC_W(PC_W), .ID_ENTRIES(ID_ENTRIES), .SET_ENTRIES(SET_ENTRIES),
    .OFF_BITS(OFF_BITS), .NRD(NRD)
  ) u_idtab (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .viol_v_i(viol_v_i), .viol_st_pc_i(viol_st_pc_i), .viol_ld_pc_i(viol_ld_pc_i),
    .rd_pc_i(rd_pc), .rd_vld_o(rd_vld), .rd_id_o(rd_id)
  );

  // Named events between the two tables.
  logic             ins_ev, iss_ev, look_hit;
  logic             set_rd_vld;
  logic [SEQ_W-1:0] set_rd_seq;
  logic [SET_ENTRIES-1:0] set_vld;

  assign ins_ev = st_ins_v_i && rd_vld[RD_INS];
  assign iss_ev = iss_v_i && iss_is_st_i && rd_vld[RD_ISS];

  sspred_lastst #(
    .SEQ_W(SEQ_W), .SET_ENTRIES(SET_ENTRIES), .THREADS(THREADS)
  ) u_lastst (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .ins_v_i(ins_ev), .ins_set_i(rd_id[RD_INS]), .ins_seq_i(st_ins_seq_i),
    .ins_tid_i(st_ins_tid_i),
    .iss_v_i(iss_ev), .iss_set_i(rd_id[RD_ISS]), .iss_seq_i(iss_seq_i),
    .sq_v_i(sq_v_i), .sq_tid_i(sq_tid_i), .sq_seq_i(sq_seq_i),
    .rd_set_i(rd_id[RD_LOOK]), .rd_vld_o(set_rd_vld), .rd_seq_o(set_rd_seq),
    .vld_vec_o(set_vld)
  );

  assign look_hit = rd_vld[RD_LOOK] && set_rd_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      look_vld_o <= 1'b0;
      look_dep_o <= '0;
    end else begin
      look_vld_o <= look_v_i;
      if (look_v_i) look_dep_o <= look_hit ? set_rd_seq : '0;
    end
  end

  // R6: the answer arrives one edge after the strobe
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    look_v_i |=> look_vld_o);

  // R6: a miss answers zero
  a_r6_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (look_v_i && !look_hit) |=> (look_dep_o == '0));

  // R5: a store with no trained set leaves the last-store table alone
  a_r5_untrained_store: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ins_v_i && !rd_vld[RD_INS] && !clr_i && !sq_v_i && !iss_ev) |=> $stable(set_vld));

  // R9: a lone load insert with known operands moves no state
  a_r9_load_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ins_v_i && !$isunknown({ld_ins_pc_i, ld_ins_seq_i}) && !clr_i && !viol_v_i &&
     !st_ins_v_i && !iss_v_i && !sq_v_i) |=> $stable(set_vld));

endmodule

// File: tb/sspred_top_tb_top.sv
`timescale 1ns/1ps
module sspred_top_tb_top;

  localparam int PC_W = 32;
  localparam int SEQ_W = 16;
  localparam real TCK = 8.0;

  localparam logic [2:0] OP_LOOK = 3'd0, OP_VIOL = 3'd1, OP_STI = 3'd2,
                         OP_LDI = 3'd3, OP_ISS = 3'd4, OP_SQ = 3'd5, OP_CLR = 3'd6;

  typedef struct packed {
    logic [2:0]       op;
    logic [PC_W-1:0]  pa;
    logic [PC_W-1:0]  pb;
    logic [SEQ_W-1:0] seq;
    logic             tid;
    logic             flg;
    logic [SEQ_W-1:0] exp;
    logic [3:0]       rq;
  } vec_t;

  function automatic vec_t mk(logic [2:0] op, logic [31:0] pa, logic [31:0] pb,
                              logic [15:0] seq, logic tid, logic flg,
                              logic [15:0] exp, logic [3:0] rq);
    vec_t v;
    v.op = op; v.pa = pa; v.pb = pb; v.seq = seq; v.tid = tid; v.flg = flg;
    v.exp = exp; v.rq = rq;
    return v;
  endfunction

  // PCs below 1024 with OFF_BITS=2: slot = PC[7:2], fresh ID = PC[3:0].
  localparam logic [31:0] PA = 32'h004, PB = 32'h008, PC_ = 32'h00C, PD = 32'h010,
                          PE = 32'h014, PF = 32'h018, PAL = 32'h1404,
                          PG = 32'h1420, PH = 32'h024, PK = 32'h0E5, PKL = 32'h0E8;

  localparam int NV = 48;
  localparam vec_t VECS [NV] = '{
    mk(OP_LOOK, PA, 0, 0, 0, 0, 16'd0, 4'd10),   // R10 empty tables
    mk(OP_STI,  PA, 0, 10, 0, 0, 0, 4'd5),       // R5 untrained: dropped
    mk(OP_VIOL, PA, PB, 0, 0, 0, 0, 4'd2),       // R2 both get ID 4
    mk(OP_LOOK, PB, 0, 0, 0, 0, 16'd0, 4'd5),    // R5 set 4 never written
    mk(OP_STI,  PA, 0, 11, 0, 0, 0, 4'd5),
    mk(OP_LOOK, PB, 0, 0, 0, 0, 16'd11, 4'd2),   // R2 shared set
    mk(OP_LOOK, PA, 0, 0, 0, 0, 16'd11, 4'd6),   // R6
    mk(OP_LDI,  PB, 0, 12, 0, 0, 0, 4'd9),       // R9 load insert
    mk(OP_LOOK, PB, 0, 0, 0, 0, 16'd11, 4'd9),
    mk(OP_ISS,  PA, 0, 10, 0, 1, 0, 4'd7),       // R7 stale seq
    mk(OP_LOOK, PB, 0, 0, 0, 0, 16'd11, 4'd7),
    mk(OP_ISS,  PA, 0, 11, 0, 0, 0, 4'd7),       // R7 as load
    mk(OP_LOOK, PB, 0, 0, 0, 0, 16'd11, 4'd7),
    mk(OP_ISS,  PA, 0, 11, 0, 1, 0, 4'd7),       // R7 match
    mk(OP_LOOK, PB, 0, 0, 0, 0, 16'd0, 4'd7),
    mk(OP_VIOL, PC_, PD, 0, 0, 0, 0, 4'd2),      // ID 12
    mk(OP_STI,  PC_, 0, 20, 1, 0, 0, 4'd5),
    mk(OP_LOOK, PD, 0, 0, 0, 0, 16'd20, 4'd2),
    mk(OP_VIOL, PA, PD, 0, 0, 0, 0, 4'd4),       // R4 min(4,12)=4
    mk(OP_STI,  PC_, 0, 21, 1, 0, 0, 4'd4),      // set 12 only
    mk(OP_LOOK, PD, 0, 0, 0, 0, 16'd0, 4'd4),    // R4 D left set 12
    mk(OP_STI,  PA, 0, 22, 0, 0, 0, 4'd4),
    mk(OP_LOOK, PD, 0, 0, 0, 0, 16'd22, 4'd4),
    mk(OP_VIOL, PAL, PE, 0, 0, 0, 0, 4'd3),      // R3 store valid via alias
    mk(OP_LOOK, PE, 0, 0, 0, 0, 16'd22, 4'd3),
    mk(OP_LOOK, PAL, 0, 0, 0, 0, 16'd22, 4'd1),  // R1 alias of slot 1
    mk(OP_VIOL, PF, PD, 0, 0, 0, 0, 4'd3),       // R3 load side valid
    mk(OP_LOOK, PF, 0, 0, 0, 0, 16'd22, 4'd3),
    mk(OP_SQ,   0, 0, 21, 1, 0, 0, 4'd8),        // R8 equal kept
    mk(OP_LOOK, PC_, 0, 0, 0, 0, 16'd21, 4'd8),
    mk(OP_SQ,   0, 0, 30, 0, 0, 0, 4'd8),
    mk(OP_LOOK, PA, 0, 0, 0, 0, 16'd22, 4'd8),
    mk(OP_SQ,   0, 0, 20, 1, 0, 0, 4'd8),        // R8 drop set 12
    mk(OP_LOOK, PC_, 0, 0, 0, 0, 16'd0, 4'd8),
    mk(OP_LOOK, PA, 0, 0, 0, 0, 16'd22, 4'd8),   // other thread kept
    mk(OP_SQ,   0, 0, 5, 0, 0, 0, 4'd8),
    mk(OP_LOOK, PA, 0, 0, 0, 0, 16'd0, 4'd8),
    mk(OP_VIOL, PK, PKL, 0, 0, 0, 0, 4'd2),      // ID 5
    mk(OP_VIOL, PG, PH, 0, 0, 0, 0, 4'd2),       // 0x1420^0x5 -> ID 5
    mk(OP_STI,  PK, 0, 41, 0, 0, 0, 4'd2),
    mk(OP_LOOK, PG, 0, 0, 0, 0, 16'd41, 4'd2),
    mk(OP_LOOK, PH, 0, 0, 0, 0, 16'd41, 4'd2),
    mk(OP_CLR,  0, 0, 0, 0, 0, 0, 4'd9),         // R9 clear
    mk(OP_LOOK, PG, 0, 0, 0, 0, 16'd0, 4'd9),
    mk(OP_STI,  PH, 0, 50, 0, 0, 0, 4'd9),
    mk(OP_LOOK, PH, 0, 0, 0, 0, 16'd0, 4'd9),
    mk(OP_LOOK, PA, 0, 0, 0, 0, 16'd0, 4'd9),
    mk(OP_LOOK, PB, 0, 0, 0, 0, 16'd0, 4'd9)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr_i, viol_v_i, st_ins_v_i, ld_ins_v_i, look_v_i, iss_v_i, iss_is_st_i, sq_v_i;
  logic [PC_W-1:0] viol_st_pc_i, viol_ld_pc_i, st_ins_pc_i, ld_ins_pc_i, look_pc_i, iss_pc_i;
  logic [SEQ_W-1:0] st_ins_seq_i, ld_ins_seq_i, iss_seq_i, sq_seq_i;
  logic st_ins_tid_i, sq_tid_i;
  logic look_vld_o;
  logic [SEQ_W-1:0] look_dep_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  sspred_top dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .viol_v_i(viol_v_i), .viol_st_pc_i(viol_st_pc_i), .viol_ld_pc_i(viol_ld_pc_i),
    .st_ins_v_i(st_ins_v_i), .st_ins_pc_i(st_ins_pc_i), .st_ins_seq_i(st_ins_seq_i),
    .st_ins_tid_i(st_ins_tid_i),
    .ld_ins_v_i(ld_ins_v_i), .ld_ins_pc_i(ld_ins_pc_i), .ld_ins_seq_i(ld_ins_seq_i),
    .look_v_i(look_v_i), .look_pc_i(look_pc_i),
    .look_vld_o(look_vld_o), .look_dep_o(look_dep_o),
    .iss_v_i(iss_v_i), .iss_pc_i(iss_pc_i), .iss_seq_i(iss_seq_i), .iss_is_st_i(iss_is_st_i),
    .sq_v_i(sq_v_i), .sq_tid_i(sq_tid_i), .sq_seq_i(sq_seq_i)
  );

  task automatic idle();
    clr_i = 0; viol_v_i = 0; st_ins_v_i = 0; ld_ins_v_i = 0; look_v_i = 0;
    iss_v_i = 0; iss_is_st_i = 0; sq_v_i = 0;
    viol_st_pc_i = '0; viol_ld_pc_i = '0; st_ins_pc_i = '0; ld_ins_pc_i = '0;
    look_pc_i = '0; iss_pc_i = '0; st_ins_seq_i = '0; ld_ins_seq_i = '0;
    iss_seq_i = '0; sq_seq_i = '0; st_ins_tid_i = 0; sq_tid_i = 0;
  endtask

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    unique case (v.op)
      OP_LOOK: begin look_v_i = 1; look_pc_i = v.pa; end
      OP_VIOL: begin viol_v_i = 1; viol_st_pc_i = v.pa; viol_ld_pc_i = v.pb; end
      OP_STI:  begin st_ins_v_i = 1; st_ins_pc_i = v.pa; st_ins_seq_i = v.seq;
                     st_ins_tid_i = v.tid; end
      OP_LDI:  begin ld_ins_v_i = 1; ld_ins_pc_i = v.pa; ld_ins_seq_i = v.seq; end
      OP_ISS:  begin iss_v_i = 1; iss_pc_i = v.pa; iss_seq_i = v.seq;
                     iss_is_st_i = v.flg; end
      OP_SQ:   begin sq_v_i = 1; sq_tid_i = v.tid; sq_seq_i = v.seq; end
      default: clr_i = 1;
    endcase
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R10: outputs idle in reset and right after it
    check("R10", {31'd0, look_vld_o}, 32'd0);
    check("R10", 32'(look_dep_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {31'd0, look_vld_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      idle();
      // R6: look_vld_o is high exactly one cycle after a lookup strobe
      check($sformatf("R%0d vec %0d vld", VECS[i].rq, i), {31'd0, look_vld_o},
            {31'd0, VECS[i].op == OP_LOOK});
      if (VECS[i].op == OP_LOOK)
        check($sformatf("R%0d vec %0d dep", VECS[i].rq, i), 32'(look_dep_o),
              32'(VECS[i].exp));
    end

    // R6: without a strobe the answer register holds its value
    @(negedge clk);
    check("R6 hold", {31'd0, look_vld_o}, 32'd0);

    // R10: reset mid-run empties tables
    drive(mk(OP_VIOL, PA, PB, 0, 0, 0, 0, 0)); @(negedge clk); idle();
    drive(mk(OP_STI, PA, 0, 77, 0, 0, 0, 0)); @(negedge clk); idle();
    drive(mk(OP_LOOK, PB, 0, 0, 0, 0, 0, 0)); @(negedge clk); idle();
    check("R5 pre-reset", 32'(look_dep_o), 32'd77);
    rst_n = 1'b0; @(negedge clk);
    check("R10 reset", 32'(look_dep_o), 32'd0);
    rst_n = 1'b1; @(negedge clk);
    drive(mk(OP_LOOK, PB, 0, 0, 0, 0, 0, 0)); @(negedge clk); idle();
    check("R10 after reset", 32'(look_dep_o), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule